// File: doc/BRIEF.md
# Windowed Watchdog with Keyed Service

This block is a watchdog timer that a host keeps from expiring by writing an ordered pair of key bytes into an 8-bit service register. A 3-bit rate select sets the timeout length, and the value zero turns the watchdog off. When it is enabled, a free-running counter advances on every clock. If the counter reaches the end of the selected period before a complete key pair has been written, the block raises a reset request.

A complete key pair is 0x55 followed later by 0xAA. The two writes need not be adjacent, and 0x55 may be repeated any number of times before the 0xAA. Writing any other value, or writing 0xAA before any 0x55, raises a reset request on the spot.

An optional window mode makes every write fatal during the first three quarters of the period. In window mode, key writes are only accepted in the final quarter. The reset request is a one-cycle pulse, and the system uses it to reset the chip.

Top module: `wdog_keyed`

## Requirements
- R1: When rate_sel is 0, the watchdog is disabled: no write of any value raises rst_req, and no timeout occurs.
- R2: When rate_sel = s is nonzero, a watchdog left without service raises rst_req 2^(2s+6) clock cycles after its counter last cleared.
- R3: Writing 0x55 and then 0xAA restarts the timeout period. The counter clears at the clock edge that accepts the 0xAA.
- R4: While enabled, a write of any value other than 0x55 or 0xAA raises rst_req in the cycle after the write.
- R5: The two key writes may be separated by any number of cycles without a write.
- R6: Repeated 0x55 writes are legal and keep the sequence armed, so a later 0xAA completes it.
- R7: While enabled, a write of 0xAA with no armed 0x55 raises rst_req in the cycle after the write.
- R8: If the key pair is not completed by the end of the period, rst_req is raised. A 0x55 alone does not extend the period.
- R9: With window_en set, a write of any value while the counter is below three quarters of the period raises rst_req in the next cycle.
- R10: With window_en set, a key pair written in the final quarter of the period is accepted and restarts the period.
- R11: rd_data always reads 0x00.
- R12: Every reset request clears the counter and the armed flag, so after a timeout an 0xAA with no new 0x55 is a bad write.
- R13: rst_req is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Timeout select, where 0 disables and s gives a period of 2^(2s+6) cycles |
| window_en | input | 1 | Makes writes fatal in the first 75% of the period |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Byte written to the service register |
| rd_data | output | 8 | Read value of the service register, always zero |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest case to reach from the ports is the armed flag surviving, or failing to survive, a timeout. The bench arms the sequence with 0x55, lets the period expire, and then writes 0xAA, which must be treated as a bad write. The window boundary is reached by idling a counted number of cycles before writing, with the count placed on either side of the three-quarter mark. A behavioural model then follows a long pseudo-random mix of key writes, bad writes, rate changes and window toggles, and is compared with the design on every clock.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int BASE_SHIFT = 6,
  parameter int STEP_SHIFT = 2,
  parameter logic [7:0] KEY_ARM  = 8'h55,
  parameter logic [7:0] KEY_FIRE = 8'hAA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       window_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       rst_req
);
  localparam int CW = BASE_SHIFT + STEP_SHIFT * 7 + 1;

  logic [CW-1:0] cnt;
  logic          armed;
  logic [CW-1:0] term, win_start;
  logic          enabled, early, service, fault, expired;

  assign enabled   = rate_sel != 3'd0;
  assign term      = CW'(1) << (BASE_SHIFT + STEP_SHIFT * int'(rate_sel));
  assign win_start = term - (term >> 2);
  assign early     = window_en && (cnt < win_start);
  assign service   = enabled && wr_en && !early && wr_data == KEY_FIRE && armed;
  assign expired   = enabled && (cnt >= term - CW'(1));
  assign fault     = enabled && ((wr_en && !service && (early || wr_data != KEY_ARM))
                                 || (expired && !service));
  assign rd_data   = 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      armed   <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fault;
      if (!enabled || fault || service) begin
        cnt   <= '0;
        armed <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
        if (wr_en && wr_data == KEY_ARM) armed <= 1'b1;
      end
    end
  end

  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd0) |=> !rst_req);

  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && rate_sel == $past(rate_sel)) |-> cnt < term);

  p_service_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && wr_en && wr_data == KEY_FIRE && armed && !early) |=> (cnt == '0 && !rst_req));

  p_bad_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && wr_en && wr_data != KEY_ARM && wr_data != KEY_FIRE) |=> rst_req);

  p_unarmed_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && wr_en && wr_data == KEY_FIRE && !armed) |=> rst_req);

  p_early_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (enabled && window_en && wr_en && cnt < win_start) |=> rst_req);

  p_req_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0 && !armed));

  always_comb p_read_zero_r11: assert (rd_data == 8'h00);
endmodule

// File: tb/sim_wdog_keyed.sv
module sim_wdog_keyed;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic window_en = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic rst_req;

  always #4 clk = ~clk;

  wdog_keyed u0 (.clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .window_en(window_en),
                 .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rst_req(rst_req));

  int n_chk = 0, n_fail = 0;
  string cur_req = "R2";
  longint mcnt = 0;
  bit marm = 0, mrst = 0, prev_rst = 0;
  int n_rise = 0, n_high = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = 0; marm = 0; mrst = 0;
    end else begin
      longint term;
      bit flt, svc;
      term = longint'(1) << (2 * int'(rate_sel) + 6);
      flt = 0; svc = 0;
      if (rate_sel == 0) begin
        mcnt = 0; marm = 0;
      end else begin
        if (wr_en) begin
          if (window_en && mcnt < term * 3 / 4) flt = 1;
          else if (wr_data == 8'h55) marm = 1;
          else if (wr_data == 8'hAA && marm) svc = 1;
          else flt = 1;
        end
        if (!svc && !flt && mcnt >= term - 1) flt = 1;
        if (flt || svc) begin mcnt = 0; marm = 0; end
        else mcnt = mcnt + 1;
      end
      mrst = flt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rst_req === mrst, cur_req, rst_req, mrst);
      chk(rd_data === 8'h00, "R11", rd_data, 0);
      if (rst_req) n_high++;
      if (rst_req && !prev_rst) n_rise++;
    end
    prev_rst = rst_req;
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic restart(logic [2:0] s, bit w);
    @(negedge clk); rate_sel = 0; window_en = 0;
    idle(3);
    rate_sel = s; window_en = w;
  endtask

  task automatic expect_pulses(int base_r, int base_h, int exp, string req);
    chk(n_rise - base_r == exp, req, n_rise - base_r, exp);
    chk(n_high - base_h == exp, "R13", n_high - base_h, exp);
  endtask

  int br, bh;
  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    idle(3);
    chk(rst_req === 1'b0, "R13", rst_req, 0);
    chk(rd_data === 8'h00, "R11", rd_data, 0);
    rst_n = 1;

    cur_req = "R1";
    br = n_rise; bh = n_high;
    wr(8'h12); wr(8'hAA); wr(8'h55); idle(600);
    expect_pulses(br, bh, 0, "R1");

    cur_req = "R2";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    idle(300); expect_pulses(br, bh, 1, "R2");
    restart(3'd2, 0); br = n_rise; bh = n_high;
    idle(1000); expect_pulses(br, bh, 0, "R2");
    idle(50); expect_pulses(br, bh, 1, "R2");

    cur_req = "R3";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    idle(200); wr(8'h55); wr(8'hAA); idle(200);
    expect_pulses(br, bh, 0, "R3");
    idle(100); expect_pulses(br, bh, 1, "R3");

    cur_req = "R5";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    idle(100); wr(8'h55); idle(50); wr(8'hAA); idle(200);
    expect_pulses(br, bh, 0, "R5");

    cur_req = "R6";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    idle(60); wr(8'h55); idle(20); wr(8'h55); wr(8'h55); idle(30); wr(8'hAA); idle(200);
    expect_pulses(br, bh, 0, "R6");

    cur_req = "R4";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    idle(10); wr(8'h3C); idle(2);
    expect_pulses(br, bh, 1, "R4");

    cur_req = "R7";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    idle(5); wr(8'hAA); idle(2);
    expect_pulses(br, bh, 1, "R7");

    cur_req = "R8";
    restart(3'd1, 0); br = n_rise; bh = n_high;
    wr(8'h55); idle(300);
    expect_pulses(br, bh, 1, "R8");
    cur_req = "R12";
    br = n_rise; bh = n_high;
    wr(8'hAA); idle(2);
    expect_pulses(br, bh, 1, "R12");

    cur_req = "R9";
    restart(3'd1, 1); br = n_rise; bh = n_high;
    idle(50); wr(8'h55); idle(2);
    expect_pulses(br, bh, 1, "R9");
    restart(3'd1, 1); br = n_rise; bh = n_high;
    idle(185); wr(8'h55); idle(2);
    expect_pulses(br, bh, 1, "R9");

    cur_req = "R10";
    restart(3'd1, 1); br = n_rise; bh = n_high;
    idle(200); wr(8'h55); wr(8'hAA); idle(150);
    expect_pulses(br, bh, 0, "R10");
    idle(150); expect_pulses(br, bh, 1, "R10");

    cur_req = "R3";
    restart(3'd1, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) wr(8'h55);
      else if (r < 5) wr(8'hAA);
      else if (r == 5) wr(8'($urandom_range(0, 255)));
      else if (r == 6) begin @(negedge clk); rate_sel = 3'($urandom_range(0, 2)); end
      else if (r == 7) begin @(negedge clk); window_en = ~window_en; end
      else idle(1);
    end

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule